// File: doc/BRIEF.md
# Async SRAM-Bus FIFO Slave Port

This block lets an external microcontroller drain an on-chip word stream over an asynchronous SRAM-style bus. The bus uses active-low chip enable, output enable and write enable, an 8-bit address and 16-bit data. All three strobes are brought into the system clock through two-flop synchronizers. A small state machine then captures the address, checks that it is stable, and follows each output-enable cycle to its end.

Address bit 7 decides what an access reaches. With bit 7 set, the access goes to a register at that address. With bit 7 clear, it goes to the streaming data port of the channel held in the control register. The stream sits in four ring buffers of 1024 bytes each, so each buffer holds 512 words. A producer-side interface fills the buffers in the system clock domain.

The master first polls the status register. When a buffer is ready, it may read the words-left register and then reads 512 words from one data-port address. Each time a buffer empties, it goes back to the producer and the block pulses a consumed event.

Top module: `sram_fifo_port`

## Requirements
- R1: Address bit 7 splits the bus. When it is 1, the access reads or writes the register at the full address. When it is 0, the access reaches the data port of the channel in control register 0x83 bits [1:0]. Any bit-7-clear address is valid for the data port. Only channel 0 carries the stream. A data-port read with any other channel returns 0, moves nothing and flags nothing. Unmapped register addresses read 0.
- R2: data_oe_o is 1 exactly while ce_ni and oe_ni are both low. It is 0 when only chip enable is low.
- R3: Words come out of the data port in the order the producer wrote them. The first read after a buffer becomes ready returns that buffer's first word.
- R4: Each buffer yields exactly 512 words. The read that completes the 512th word releases the buffer, pulses cons_evt_o high for one clock and adds 1 to the 16-bit consumed counter at register 0x82.
- R5: Status register 0x80 holds ready in bit 0, the underflow flag in bit 1 and the count of full buffers from bit 2 upward. Ready is 1 whenever at least one buffer is full. It falls to 0 once the last full buffer has been released.
- R6: prod_ready_o is 1 while fewer than 4 buffers are full. Producer words offered while it is 0 are dropped and leave stored data intact. Releasing a buffer raises prod_ready_o again.
- R7: A data-port read on channel 0 while no buffer is ready returns 0 and does not move the read pointer. It sets the sticky underflow bit (0x80 bit 1). Writing a 1 to bit 1 of 0x80 clears that bit.
- R8: The read pointer moves once per completed output-enable cycle, when output enable rises. This holds whether output enable falls after chip enable or together with it. The address-compare state enters the armed-read state only while output enable is idle. Otherwise it goes straight to the drive state.
- R9: Register 0x81 holds the words still unread in the current buffer: 512 minus the words read so far, or 0 when no buffer is ready.
- R10: After reset, data_oe_o and cons_evt_o are 0, prod_ready_o is 1, and registers 0x80, 0x82 and 0x83 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ce_ni | input | 1 | Bus chip enable, active low, asynchronous |
| oe_ni | input | 1 | Bus output enable, active low, asynchronous |
| we_ni | input | 1 | Bus write enable, active low, asynchronous |
| addr_i | input | 8 | Bus address; bit 7 selects register or data port |
| data_i | input | 16 | Bus write data for register writes |
| data_o | output | 16 | Bus read data |
| data_oe_o | output | 1 | Drive enable for the bus data pins |
| prod_valid_i | input | 1 | Producer offers a word |
| prod_data_i | input | 16 | Producer word |
| prod_ready_o | output | 1 | A buffer has room; a word is taken when valid and ready |
| cons_evt_o | output | 1 | One-clock pulse when a buffer has been fully read |

## Verification
Read data is valid about three clocks after chip enable falls: two synchronizer flops plus the address-capture register. The bench therefore holds each strobe phase for five clocks and samples data on a falling clock edge near the end of the output-enable phase. The pointer advance, the underflow flag and the consumed counter all follow the synchronized rise of output enable by about three clocks, and the consumed pulse lands one clock after that. For this reason every access ends with six idle clocks before the next register read or pulse-count check. Register writes commit on the synchronized rise of write enable, and the bench reads the value back only after chip enable has returned high.

// File: rtl/sram_fifo_pkg.sv
package sram_fifo_pkg;
  typedef enum logic [2:0] {
    BUS_IDLE,
    BUS_ADDR_CMP,
    BUS_ARMED,
    BUS_DRIVE
  } bus_state_e;

  localparam logic [7:0] REG_STATUS = 8'h80;
  localparam logic [7:0] REG_LEFT   = 8'h81;
  localparam logic [7:0] REG_CONS   = 8'h82;
  localparam logic [7:0] REG_CTRL   = 8'h83;
endpackage

// File: rtl/sfp_sync.sv
module sfp_sync #(
  parameter int  N       = 3,
  parameter bit  RST_VAL = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= RST_VAL;
        s2_q <= RST_VAL;
      end else begin
        s1_q <= d_i[i];
        s2_q <= s1_q;
      end
    end
    assign q_o[i] = s2_q;
  end
endmodule

// File: rtl/sfp_bus_fsm.sv
module sfp_bus_fsm
  import sram_fifo_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_s_i,
  input  logic          oe_s_i,
  input  logic          we_s_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic          rd_done_o,
  output logic          wr_commit_o
);
  bus_state_e    state_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          we_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= BUS_IDLE;
      addr_q  <= '0;
    end else begin
      unique case (state_q)
        BUS_IDLE: if (!ce_s_i) begin
          addr_q  <= addr_i;
          state_q <= BUS_ADDR_CMP;
        end
        BUS_ADDR_CMP: begin
          if (ce_s_i)                 state_q <= BUS_IDLE;
          else if (addr_i != addr_q)  addr_q  <= addr_i;
          else if (oe_s_i)            state_q <= BUS_ARMED;  // oe idle: arm
          else                        state_q <= BUS_DRIVE;  // oe already low: no skip
        end
        BUS_ARMED: begin
          if (ce_s_i)       state_q <= BUS_IDLE;
          else if (!oe_s_i) state_q <= BUS_DRIVE;
        end
        BUS_DRIVE: if (oe_s_i) state_q <= ce_s_i ? BUS_IDLE : BUS_ARMED;
        default: state_q <= BUS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wdata_q   <= '0;
      we_prev_q <= 1'b1;
    end else begin
      we_prev_q <= we_s_i;
      if (!we_s_i) wdata_q <= data_i;
    end
  end

  assign rd_done_o   = (state_q == BUS_DRIVE) && oe_s_i;
  assign wr_commit_o = we_s_i && !we_prev_q && (state_q != BUS_IDLE);
  assign addr_o      = addr_q;
  assign wdata_o     = wdata_q;

  assert_done_once_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_done_o |=> !rd_done_o);
  assert_arm_oe_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == BUS_ARMED && $past(state_q) == BUS_ADDR_CMP) |-> $past(oe_s_i));
  assert_drive_from_cmp_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == BUS_ADDR_CMP && !ce_s_i && addr_i == addr_q && !oe_s_i) |=> state_q == BUS_DRIVE);
endmodule

// File: rtl/sfp_buffers.sv
module sfp_buffers #(
  parameter int DW    = 16,
  parameter int NBUF  = 4,
  parameter int WORDS = 512,
  localparam int BW   = $clog2(NBUF),
  localparam int WW   = $clog2(WORDS),
  localparam int CW   = $clog2(NBUF + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_valid_i,
  input  logic [DW-1:0] push_data_i,
  output logic          push_ready_o,
  input  logic          pop_i,
  output logic [DW-1:0] head_o,
  output logic [WW-1:0] rd_word_o,
  output logic [CW-1:0] full_cnt_o,
  output logic          cons_o
);
  logic [DW-1:0] mem [NBUF*WORDS];
  logic [BW-1:0] wr_buf_q, rd_buf_q;
  logic [WW-1:0] wr_word_q, rd_word_q;
  logic [CW-1:0] full_cnt_q;
  logic          cons_q;
  logic          push, fill_done, release_buf;

  assign push_ready_o = full_cnt_q < CW'(NBUF);
  assign push         = push_valid_i && push_ready_o;
  assign fill_done    = push && (wr_word_q == WW'(WORDS - 1));
  assign release_buf  = pop_i && (rd_word_q == WW'(WORDS - 1));

  always_ff @(posedge clk_i) begin
    if (push) mem[{wr_buf_q, wr_word_q}] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_buf_q   <= '0;
      wr_word_q  <= '0;
      rd_buf_q   <= '0;
      rd_word_q  <= '0;
      full_cnt_q <= '0;
      cons_q     <= 1'b0;
    end else begin
      cons_q <= release_buf;
      if (push) begin
        wr_word_q <= fill_done ? '0 : wr_word_q + 1'b1;
        if (fill_done) wr_buf_q <= wr_buf_q + 1'b1;
      end
      if (pop_i) begin
        rd_word_q <= release_buf ? '0 : rd_word_q + 1'b1;
        if (release_buf) rd_buf_q <= rd_buf_q + 1'b1;
      end
      if (fill_done && !release_buf)      full_cnt_q <= full_cnt_q + 1'b1;
      else if (release_buf && !fill_done) full_cnt_q <= full_cnt_q - 1'b1;
    end
  end

  assign head_o     = mem[{rd_buf_q, rd_word_q}];
  assign rd_word_o  = rd_word_q;
  assign full_cnt_o = full_cnt_q;
  assign cons_o     = cons_q;

  assert_pop_ready_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> full_cnt_q != '0);
  assert_cnt_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_cnt_q <= CW'(NBUF));
  assert_cons_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cons_q |=> !cons_q);
  assert_rd_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pop_i |=> $stable(rd_word_q));
endmodule

// File: rtl/sram_fifo_port.sv
module sram_fifo_port
  import sram_fifo_pkg::*;
#(
  parameter int AW        = 8,
  parameter int DW        = 16,
  parameter int NBUF      = 4,
  parameter int BUF_BYTES = 1024,
  localparam int WORDS    = BUF_BYTES / (DW / 8),
  localparam int WW       = $clog2(WORDS),
  localparam int CW       = $clog2(NBUF + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_ni,
  input  logic          oe_ni,
  input  logic          we_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o,
  input  logic          prod_valid_i,
  input  logic [DW-1:0] prod_data_i,
  output logic          prod_ready_o,
  output logic          cons_evt_o
);
  logic [2:0]    strb_s;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, head, reg_rd;
  logic          rd_done, wr_commit, ready, port_rd, chan0, pop, uf_clr;
  logic [WW-1:0] rd_word;
  logic [CW-1:0] full_cnt;
  logic          uf_q;
  logic [1:0]    chan_q;
  logic [DW-1:0] cons_cnt_q;

  sfp_sync #(.N(3), .RST_VAL(1'b1)) u_sync (
    .clk_i, .rst_ni,
    .d_i ({we_ni, oe_ni, ce_ni}),
    .q_o (strb_s)
  );

  sfp_bus_fsm #(.AW(AW), .DW(DW)) u_fsm (
    .clk_i, .rst_ni,
    .ce_s_i     (strb_s[0]),
    .oe_s_i     (strb_s[1]),
    .we_s_i     (strb_s[2]),
    .addr_i,
    .data_i,
    .addr_o     (addr_q),
    .wdata_o    (wdata_q),
    .rd_done_o  (rd_done),
    .wr_commit_o(wr_commit)
  );

  assign ready   = full_cnt != '0;
  assign chan0   = chan_q == 2'd0;
  assign port_rd = rd_done && !addr_q[AW-1] && chan0;
  assign pop     = port_rd && ready;
  assign uf_clr  = wr_commit && addr_q == REG_STATUS && wdata_q[1];

  sfp_buffers #(.DW(DW), .NBUF(NBUF), .WORDS(WORDS)) u_buf (
    .clk_i, .rst_ni,
    .push_valid_i(prod_valid_i),
    .push_data_i (prod_data_i),
    .push_ready_o(prod_ready_o),
    .pop_i       (pop),
    .head_o      (head),
    .rd_word_o   (rd_word),
    .full_cnt_o  (full_cnt),
    .cons_o      (cons_evt_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      uf_q       <= 1'b0;
      chan_q     <= '0;
      cons_cnt_q <= '0;
    end else begin
      if (port_rd && !ready) uf_q <= 1'b1;
      else if (uf_clr)       uf_q <= 1'b0;
      if (wr_commit && addr_q == REG_CTRL) chan_q <= wdata_q[1:0];
      if (cons_evt_o) cons_cnt_q <= cons_cnt_q + 1'b1;
    end
  end

  always_comb begin
    unique case (addr_q)
      REG_STATUS: reg_rd = DW'({full_cnt, uf_q, ready});
      REG_LEFT:   reg_rd = ready ? DW'(WORDS) - DW'(rd_word) : '0;
      REG_CONS:   reg_rd = cons_cnt_q;
      REG_CTRL:   reg_rd = DW'(chan_q);
      default:    reg_rd = '0;
    endcase
  end

  assign data_o    = addr_q[AW-1] ? reg_rd : ((chan0 && ready) ? head : '0);
  assign data_oe_o = !ce_ni && !oe_ni;

  assert_uf_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uf_q && !uf_clr) |=> uf_q);
  assert_cons_count_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cons_evt_o |=> cons_cnt_q == $past(cons_cnt_q) + 1'b1);
  assert_no_pop_other_chan_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chan0 |-> !pop);
endmodule

// File: tb/tb_sram_fifo_port.sv
module tb_sram_fifo_port;
  localparam int CLK_PERIOD = 10;
  localparam int WORDS      = 512;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ce_ni = 1'b1, oe_ni = 1'b1, we_ni = 1'b1;
  logic [7:0]  addr_i = '0;
  logic [15:0] data_i = '0;
  logic [15:0] data_o;
  logic        data_oe_o;
  logic        prod_valid_i = 1'b0;
  logic [15:0] prod_data_i = '0;
  logic        prod_ready_o;
  logic        cons_evt_o;

  int total = 0, bad = 0, cons_seen = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  sram_fifo_port dut (.*);

  always @(negedge clk_i) if (rst_ni && cons_evt_o) cons_seen++;

  function automatic logic [15:0] pat(input int s, input int w);
    return {s[3:0], w[11:0]};
  endfunction

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic bus_rd(input logic [7:0] a, input bit fast, output logic [15:0] d, output logic oe_seen);
    addr_i = a;
    ce_ni  = 1'b0;
    if (fast) oe_ni = 1'b0;
    idle(5);
    oe_ni = 1'b0;
    idle(5);
    d       = data_o;
    oe_seen = data_oe_o;
    oe_ni = 1'b1;
    ce_ni = 1'b1;
    idle(6);
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [15:0] d);
    addr_i = a;
    data_i = d;
    ce_ni  = 1'b0;
    idle(4);
    we_ni = 1'b0;
    idle(5);
    we_ni = 1'b1;
    idle(4);
    ce_ni = 1'b1;
    idle(6);
  endtask

  task automatic reg_chk(input logic [7:0] a, input logic [15:0] exp, input string req);
    logic [15:0] d;
    logic o;
    bus_rd(a, 1'b0, d, o);
    check(d == exp, req, d, exp);
  endtask

  task automatic fill(input int s);
    for (int w = 0; w < WORDS; w++) begin
      prod_valid_i = 1'b1;
      prod_data_i  = pat(s, w);
      @(negedge clk_i);
    end
    prod_valid_i = 1'b0;
    idle(2);
  endtask

  task automatic drain(input int s, input bit fast, input bit alt_addr, input string req);
    logic [15:0] d;
    logic o;
    int c0 = cons_seen;
    for (int w = 0; w < WORDS; w++) begin
      bus_rd((alt_addr && w[0]) ? 8'h7F : 8'h00, fast, d, o);
      check(d == pat(s, w), req, d, pat(s, w));
      if (w == 0) check(o == 1'b1, "R2 drive", {15'd0, o}, 16'd1);
      if (w == WORDS - 2) begin
        check(cons_seen == c0, "R4 no early release", 16'(cons_seen), 16'(c0));
        reg_chk(8'h81, 16'd1, "R9 one left");
      end
    end
    check(cons_seen == c0 + 1, "R4 consumed pulse", 16'(cons_seen), 16'(c0 + 1));
  endtask

  task automatic t_reset;
    logic [15:0] d;
    check(data_oe_o == 1'b0, "R10 oe", {15'd0, data_oe_o}, 16'd0);
    check(prod_ready_o == 1'b1, "R10 ready", {15'd0, prod_ready_o}, 16'd1);
    check(cons_evt_o == 1'b0, "R10 cons", {15'd0, cons_evt_o}, 16'd0);
    reg_chk(8'h80, 16'h0000, "R10 status");
    reg_chk(8'h82, 16'h0000, "R10 consumed");
    reg_chk(8'h83, 16'h0000, "R10 ctrl");
    reg_chk(8'h91, 16'h0000, "R1 unmapped");
    ce_ni = 1'b0;
    idle(5);
    d = {15'd0, data_oe_o};
    check(data_oe_o == 1'b0, "R2 ce only", d, 16'd0);
    ce_ni = 1'b1;
    idle(6);
  endtask

  task automatic t_underflow;
    logic [15:0] d;
    logic o;
    bus_rd(8'h00, 1'b0, d, o);
    check(d == 16'h0000, "R7 empty read data", d, 16'h0000);
    reg_chk(8'h80, 16'h0002, "R7 underflow set");
    reg_chk(8'h81, 16'h0000, "R9 none ready");
    bus_wr(8'h80, 16'h0002);
    reg_chk(8'h80, 16'h0000, "R7 underflow clear");
  endtask

  task automatic t_single_buffer;
    fill(0);
    reg_chk(8'h80, 16'h0005, "R5 one full");
    reg_chk(8'h81, 16'd512, "R9 full buffer");
    drain(0, 1'b0, 1'b0, "R3 order slow");
    reg_chk(8'h82, 16'd1, "R4 counter");
    reg_chk(8'h80, 16'h0000, "R5 ready cleared");
  endtask

  task automatic t_full_ring;
    for (int s = 1; s <= 4; s++) fill(s);
    check(prod_ready_o == 1'b0, "R6 ring full", {15'd0, prod_ready_o}, 16'd0);
    prod_valid_i = 1'b1;
    prod_data_i  = 16'hDEAD;
    idle(3);
    prod_valid_i = 1'b0;
    reg_chk(8'h80, 16'h0011, "R5 four full");
  endtask

  task automatic t_channel;
    logic [15:0] d;
    logic o;
    bus_wr(8'h83, 16'h0002);
    reg_chk(8'h83, 16'h0002, "R1 ctrl write");
    bus_rd(8'h03, 1'b0, d, o);
    check(d == 16'h0000, "R1 other channel data", d, 16'h0000);
    reg_chk(8'h81, 16'd512, "R1 no advance");
    reg_chk(8'h80, 16'h0011, "R1 no underflow");
    bus_wr(8'h83, 16'h0000);
  endtask

  task automatic t_rest;
    drain(1, 1'b1, 1'b0, "R8 oe with ce");
    check(prod_ready_o == 1'b1, "R6 released", {15'd0, prod_ready_o}, 16'd1);
    drain(2, 1'b0, 1'b1, "R1 any port address");
    drain(3, 1'b1, 1'b1, "R3 order mixed");
    drain(4, 1'b0, 1'b0, "R3 order last");
    reg_chk(8'h82, 16'd5, "R4 counter total");
    reg_chk(8'h80, 16'h0000, "R5 all drained");
  endtask

  initial begin
    idle(3);
    rst_ni = 1'b1;
    idle(3);
    t_reset();
    t_underflow();
    t_single_buffer();
    t_full_ring();
    t_channel();
    t_rest();
    finished = 1'b1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (190000) @(posedge clk_i);
        total++;
        bad++;
        $display("FAIL watchdog actual=%h expected=%h", 16'd0, 16'd1);
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule